// File: doc/BRIEF.md
# Serial EEPROM Page Write Engine

This block sits behind the bus slave front end of a serial EEPROM and turns a write transaction into array updates. The front end hands over a starting word address, then the data bytes, then a stop. Bytes go into a page latch of 32 slots, and each loaded slot is marked. The array holds 8192 bytes as 256 pages of 32 bytes. On a stop that follows at least one byte, the engine enters a self-timed write cycle. It walks the latch and writes only the marked slots into the array. It then holds a busy flag until a cycle counter expires. The counter length is set by a parameter, and the default of 1,000,000 clocks gives 10 ms at 100 MHz. The front end refuses access while busy is high.

The word address splits into a page number, which stays fixed, and a slot index, which advances after every byte and wraps inside the page. A protect input is sampled at the stop. When it is high, nothing is written to any page in the upper quarter of the address space (word addresses 0x1800 to 0x1FFF). A registered read port lets the front end fetch array bytes.

The FSM states are IDLE, FILL, COMMIT and SETTLE. The transitions are:
- accept: IDLE to FILL on a start.
- restart: FILL to FILL on a start.
- abandon: FILL to IDLE on a stop with no byte loaded.
- launch: FILL to COMMIT on a stop with a byte loaded.
- sweep_done: COMMIT to SETTLE after the last slot.
- release: SETTLE to IDLE when the timer expires.

In FILL, a stop takes priority over a start, and a start takes priority over a byte.

Top module: `eew_page_write_engine`

## Requirements
- R1: After reset `busy` is 0 and no write is pending.
- R2: A single-byte write stores that byte at the given word address.
- R3: A page write of 32 bytes starting at slot 0 fills the whole page in order.
- R4: The slot index (address bits 4:0) goes up by one after each byte and wraps from 31 to 0. The page (address bits 12:5) never changes during a transaction.
- R5: When more than 32 bytes arrive, a later byte replaces the byte latched earlier at the same wrapped slot.
- R6: Only latched slots are written. Every other byte of the page keeps its old value.
- R7: A stop with no byte loaded, or a stop while idle, starts no cycle and changes no byte.
- R8: `busy` rises on the clock edge that samples a stop after at least one byte. It stays high for exactly WRITE_CYCLES cycles when WRITE_CYCLES is at least 33.
- R9: While `busy` is high, start, byte and stop inputs are ignored.
- R10: When `wp` is 1 at the stop, no address whose bits 12:11 are 2'b11 is modified. Writes elsewhere still take effect.
- R11: When `wp` is 0, the protected quarter is written like any other page.
- R12: `wp` is sampled only at the stop. Changing it during the cycle has no effect.
- R13: `rd_data` shows the array byte at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Pulse that opens a write and captures `wr_addr` |
| wr_addr | input | 13 | Starting word address |
| byte_valid | input | 1 | Pulse that loads `byte_data` into the latch |
| byte_data | input | 8 | Data byte |
| wr_stop | input | 1 | Pulse that closes the write transaction |
| wp | input | 1 | Write protect for the upper quarter; the front end ties it to 0 when it is not connected |
| busy | output | 1 | High during the internal write cycle |
| rd_addr | input | 13 | Read word address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench sets WRITE_CYCLES to 48. This makes a complete busy window take a few dozen clocks, so the bench can measure every window exactly and see it close. The value is still above the 33-clock slot sweep, so the SETTLE state and the release transition are both exercised. Address and slot widths keep their default values. Page wrap, overflow past 32 bytes and the boundary at word address 0x1800 are therefore tested at their real positions.

// File: rtl/eew_pkg.sv
package eew_pkg;

    // Write engine states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_SETTLE = 2'd3
    } eew_state_e;

endpackage

// File: rtl/eew_page_latch.sv
module eew_page_latch #(
    parameter int SLOT_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [SLOT_W-1:0] base_slot,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              any_loaded
);
    localparam int SLOTS = 1 << SLOT_W;

    logic [DATA_W-1:0] slot_data [SLOTS];
    logic [SLOTS-1:0]  loaded_q;
    logic [SLOT_W-1:0] ptr_q;

    // Pointer and slot marks; pointer wraps naturally inside the page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_q <= '0;
            ptr_q    <= '0;
        end else if (clear) begin
            loaded_q <= '0;
            ptr_q    <= base_slot;
        end else if (load) begin
            loaded_q[ptr_q] <= 1'b1;
            ptr_q           <= ptr_q + SLOT_W'(1);
        end
    end

    // Slot storage, one register per slot
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (load && !clear && ptr_q == SLOT_W'(s)) begin
                slot_data[s] <= load_data;
            end
        end
    end

    assign rd_data    = slot_data[rd_slot];
    assign rd_loaded  = loaded_q[rd_slot];
    assign any_loaded = |loaded_q;
endmodule

// File: rtl/eew_cycle_timer.sv
module eew_cycle_timer #(
    parameter int LIMIT = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q >= CNT_W'(LIMIT - 1));

    // Saturating count of cycles since start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/eew_array.sv
module eew_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/eew_page_write_engine.sv
module eew_page_write_engine
    import eew_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int SLOT_W       = 5,
    parameter int WRITE_CYCLES = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              wr_stop,
    input  logic              wp,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAGE_W    = ADDR_W - SLOT_W;
    localparam int LAST_SLOT = (1 << SLOT_W) - 1;

    eew_state_e state_q, state_d;

    logic [PAGE_W-1:0] page_q;
    logic [SLOT_W-1:0] slot_q;
    logic              wp_q;

    logic              latch_clear, latch_load, launch;
    logic [DATA_W-1:0] lat_data;
    logic              lat_loaded, lat_any;
    logic              timer_expired;
    logic              prot_hit;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: accept, restart, abandon, launch, sweep_done, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_start) state_d = ST_FILL;
            ST_FILL: begin
                if (wr_stop) state_d = lat_any ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: if (slot_q == SLOT_W'(LAST_SLOT)) state_d = ST_SETTLE;
            ST_SETTLE: if (timer_expired) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        latch_clear = 1'b0;
        latch_load  = 1'b0;
        launch      = 1'b0;
        busy        = 1'b0;
        arr_we      = 1'b0;
        unique case (state_q)
            ST_IDLE: latch_clear = wr_start;
            ST_FILL: begin
                launch      = wr_stop && lat_any;
                latch_clear = wr_start && !wr_stop;
                latch_load  = byte_valid && !wr_stop && !wr_start;
            end
            ST_COMMIT: begin
                busy   = 1'b1;
                arr_we = lat_loaded && !(wp_q && prot_hit);
            end
            ST_SETTLE: busy = 1'b1;
            default: ;
        endcase
    end

    // Page number, protect sample and sweep index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            wp_q   <= 1'b0;
            slot_q <= '0;
        end else begin
            if (latch_clear) page_q <= wr_addr[ADDR_W-1:SLOT_W];
            if (launch) begin
                wp_q   <= wp;
                slot_q <= '0;
            end else if (state_q == ST_COMMIT) begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    // Protected region: upper quarter of the pages
    if (PAGE_W >= 2) begin : g_prot
        assign prot_hit = (page_q[PAGE_W-1 -: 2] == 2'b11);
    end else begin : g_noprot
        assign prot_hit = 1'b0;
    end

    assign arr_waddr = {page_q, slot_q};

    eew_page_latch #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (latch_clear),
        .base_slot  (wr_addr[SLOT_W-1:0]),
        .load       (latch_load),
        .load_data  (byte_data),
        .rd_slot    (slot_q),
        .rd_data    (lat_data),
        .rd_loaded  (lat_loaded),
        .any_loaded (lat_any)
    );

    eew_cycle_timer #(.LIMIT(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (launch),
        .run     (busy),
        .expired (timer_expired)
    );

    eew_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (lat_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
    parameter int ADDR_W = 13,
    parameter int SLOT_W = 5,
    parameter int LIMIT  = 1_000_000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     wr_stop,
    input logic                     arr_we,
    input logic [ADDR_W-1:0]        arr_waddr,
    input logic [ADDR_W-SLOT_W-1:0] page_q,
    input logic                     wp_q
);
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int EXPECT = (LIMIT > SLOTS) ? LIMIT : SLOTS + 1;
    localparam int RUN_W  = $clog2(EXPECT + 2);

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            if (run_len != '1) run_len <= run_len + RUN_W'(1);
        end else begin
            run_len <= '0;
        end
    end

    // R8
    busy_rise_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_stop));

    // R8
    busy_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == RUN_W'(EXPECT));

    // R6
    write_only_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R4
    write_inside_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> arr_waddr[ADDR_W-1:SLOT_W] == page_q);

    // R10
    protect_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && wp_q) |-> arr_waddr[ADDR_W-1 -: 2] != 2'b11);

    // R12
    protect_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wp_q));
endmodule

bind eew_page_write_engine eew_checker #(
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W),
    .LIMIT  (WRITE_CYCLES)
) u_eew_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wr_stop   (wr_stop),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .page_q    (page_q),
    .wp_q      (wp_q)
);

// File: tb/test_eew_page_write_engine.sv
module test_eew_page_write_engine;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int SLOT_W = 5;
    localparam int LIMIT  = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_start = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              byte_valid = 1'b0;
    logic [DATA_W-1:0] byte_data = '0;
    logic              wr_stop = 1'b0;
    logic              wp = 1'b0;
    logic              busy;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    eew_page_write_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .WRITE_CYCLES(LIMIT)
    ) i_eew_page_write_engine (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .wr_stop(wr_stop),
        .wp(wp), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Pulse tasks: entered and left at a falling edge
    task automatic begin_write(input logic [ADDR_W-1:0] a);
        wr_start = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic send_byte(input logic [DATA_W-1:0] d);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic end_write();
        wr_stop = 1'b1;
        @(negedge clk);
        wr_stop = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_byte(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic write_block(input logic [ADDR_W-1:0] a, input int n,
                               input logic [DATA_W-1:0] base);
        int w;
        begin_write(a);
        for (int i = 0; i < n; i++) send_byte(base + DATA_W'(i));
        end_write();
        wait_idle(w);
    endtask

    task automatic t_reset();
        check("R1 busy after reset", busy, 0);
    endtask

    task automatic t_full_page();
        logic [DATA_W-1:0] d;
        int n;
        begin_write(13'h040);
        for (int i = 0; i < 32; i++) send_byte(DATA_W'(1 + 3 * i));
        end_write();
        wait_idle(n);
        check("R8 busy window length", n, LIMIT);
        read_byte(13'h040, d);
        check("R13 registered read", d, 8'h01);
        for (int i = 1; i < 32; i++) begin
            read_byte(13'h040 + ADDR_W'(i), d);
            check("R3 page byte", d, DATA_W'(1 + 3 * i));
        end
    endtask

    task automatic t_single();
        logic [DATA_W-1:0] d;
        write_block(13'h045, 1, 8'hA5);
        read_byte(13'h045, d); check("R2 single byte", d, 8'hA5);
        read_byte(13'h044, d); check("R6 lower neighbour", d, 8'h0D);
        read_byte(13'h046, d); check("R6 upper neighbour", d, 8'h13);
    endtask

    task automatic t_wrap();
        logic [DATA_W-1:0] d;
        write_block(13'h060, 32, 8'h10);
        write_block(13'h080, 32, 8'h50);
        write_block(13'h07E, 4, 8'hF0);
        read_byte(13'h07E, d); check("R4 slot 30", d, 8'hF0);
        read_byte(13'h07F, d); check("R4 slot 31", d, 8'hF1);
        read_byte(13'h060, d); check("R4 wrapped slot 0", d, 8'hF2);
        read_byte(13'h061, d); check("R4 wrapped slot 1", d, 8'hF3);
        read_byte(13'h062, d); check("R6 untouched slot", d, 8'h12);
        read_byte(13'h080, d); check("R4 next page untouched", d, 8'h50);
    endtask

    task automatic t_overflow();
        logic [DATA_W-1:0] d;
        write_block(13'h0A0, 34, 8'h00);
        read_byte(13'h0A0, d); check("R5 slot 0 replaced", d, 8'd32);
        read_byte(13'h0A1, d); check("R5 slot 1 replaced", d, 8'd33);
        read_byte(13'h0A2, d); check("R5 slot 2 kept", d, 8'd2);
        read_byte(13'h0BF, d); check("R5 slot 31 kept", d, 8'd31);
    endtask

    task automatic t_empty_stop();
        begin_write(13'h0C0);
        end_write();
        check("R7 empty stop no cycle", busy, 0);
        end_write();
        check("R7 idle stop no cycle", busy, 0);
        repeat (3) @(negedge clk);
        check("R7 still idle", busy, 0);
    endtask

    task automatic t_busy_ignore();
        logic [DATA_W-1:0] d;
        int n;
        write_block(13'h0C0, 32, 8'h30);
        begin_write(13'h0C0);
        send_byte(8'h11);
        end_write();
        begin_write(13'h0C1);
        send_byte(8'h99);
        end_write();
        wait_idle(n);
        @(negedge clk);
        check("R9 no cycle after ignored stop", busy, 0);
        read_byte(13'h0C1, d); check("R9 ignored byte", d, 8'h31);
        read_byte(13'h0C0, d); check("R9 first write kept", d, 8'h11);
    endtask

    task automatic t_protect();
        logic [DATA_W-1:0] d;
        wp = 1'b0;
        write_block(13'h1800, 32, 8'h60);
        read_byte(13'h1800, d); check("R11 protected quarter writable", d, 8'h60);
        wp = 1'b1;
        write_block(13'h1800, 1, 8'hEE);
        write_block(13'h17FF, 1, 8'hDD);
        read_byte(13'h1800, d); check("R10 protected byte kept", d, 8'h60);
        read_byte(13'h17FF, d); check("R10 below region written", d, 8'hDD);
        wp = 1'b0;
    endtask

    task automatic t_wp_sample();
        logic [DATA_W-1:0] d;
        int n;
        wp = 1'b0;
        begin_write(13'h1801);
        send_byte(8'h77);
        end_write();
        wp = 1'b1;
        wait_idle(n);
        read_byte(13'h1801, d); check("R12 late raise ignored", d, 8'h77);
        begin_write(13'h1802);
        send_byte(8'h88);
        end_write();
        wp = 1'b0;
        wait_idle(n);
        read_byte(13'h1802, d); check("R12 late drop ignored", d, 8'h62);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_page();
        t_single();
        t_wrap();
        t_overflow();
        t_empty_stop();
        t_busy_ignore();
        t_protect();
        t_wp_sample();
        summary();
        $finish;
    end
endmodule